// File: doc/BRIEF.md
# Mode-Dependent Address/GPIO Port Controller

This block controls one 8-bit pin group of a microcontroller-style device. Each pin can carry a bit of the external address bus or act as a general-purpose input/output. Which one it is depends on the chip operating mode and on a per-pin direction bit. Software reaches four registers over a simple single-cycle register bus: direction (write-only), output data, pin-state readback, and pull-up control.

Two standby inputs act on the pins. Hardware standby turns every output driver off and clears the direction bits. Software standby keeps all register contents. While in software standby, a hold-enable input decides whether address pins keep their last address or float. The block drives a value, an output enable and a pull-up enable for each pin. The pad cells and the resistors themselves are outside this block.

Top module: `xport_ctrl`

## Requirements
- R1: After reset, the direction, output-data and pull-up control registers hold 0x00. A read with `bus_sel`=0 (direction) always returns the fixed filler 0xFF.
- R2: For `op_mode` 4 or 5, outside standby, every pin has its output enable set and drives the matching `addr_in` bit. The direction bits have no effect.
- R3: For `op_mode` 6, a pin whose direction bit is 1 drives its `addr_in` bit. A pin whose direction bit is 0 is an input, with its output enable off.
- R4: For `op_mode` 7, and for any code other than 4, 5 or 6, a pin whose direction bit is 1 drives its output-data bit. A pin whose direction bit is 0 is an input.
- R5: The register select codes are 0 = direction, 1 = output data, 2 = pin state, 3 = pull-up control. A write with `bus_wr` high is stored at that clock edge. `rd_data` shows the selected register without delay. A write to code 2 changes no register.
- R6: A pin-state read returns, per bit, the driven value for a pin whose output enable is set. For any other pin it returns `pad_in` after two synchronizer flops: a change becomes visible after the second clock edge and not after the first.
- R7: `pin_pu` is set only for a pin in input function whose pull-up control bit is 1, and only outside hardware standby. It is never set on a pin that is enabled to drive.
- R8: In software standby with `hold_en`=1, address pins stay enabled. They drive the `addr_in` value sampled at the last clock edge before standby began, and ignore later changes of `addr_in`.
- R9: In software standby with `hold_en`=0, address pins turn their output enable off, while general-purpose outputs keep driving. The direction register keeps its value through software standby.
- R10: While `hw_stby` is high, all output enables and pull-up enables are 0 and the direction register is cleared. A direction write made then is lost. Output data and pull-up control keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_mode | input | 3 | Chip operating mode code |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| hold_en | input | 1 | Keep address pins driven during software standby |
| addr_in | input | 8 | Internal address byte to be put on the pins |
| bus_wr | input | 1 | Register write strobe |
| bus_sel | input | 2 | Register select |
| bus_wdata | input | 8 | Register write data |
| rd_data | output | 8 | Read data of the selected register |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |
| pin_pu | output | 8 | Per-pin pull-up enable |

## Verification
The bench goes after these corner cases and the fault each one would expose:
- Modes 4 and 5 with direction bits that are mostly clear. A design that consulted the direction bits there would float some address pins.
- The moment software standby begins, with `addr_in` changing at the same edge. A hold register that kept sampling would pass the new address through.
- Hardware standby with a direction write made during it, followed by leaving standby. A design that cleared too little would switch outputs back on.
- The pin-state read one edge and two edges after a pad change. A synchronizer of the wrong depth shows the new level too early or too late.
- A write aimed at the read-only pin register. A decoder that aliased it would corrupt the data or pull-up register.

// File: rtl/xport_pkg.sv
`timescale 1ns/1ps
package xport_pkg;

  typedef enum logic [1:0] {
    SEL_DIR = 2'd0,
    SEL_DAT = 2'd1,
    SEL_PIN = 2'd2,
    SEL_PUC = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    FN_IN   = 2'd0,
    FN_ADDR = 2'd1,
    FN_GPIO = 2'd2
  } pin_fn_e;

  localparam logic [2:0] MODE_EXT_A = 3'd4;
  localparam logic [2:0] MODE_EXT_B = 3'd5;
  localparam logic [2:0] MODE_MIXED = 3'd6;

  // Function of one pin given the operating mode and its direction bit.
  function automatic pin_fn_e pin_function(input logic [2:0] mode, input logic dir_bit);
    pin_fn_e fn;
    if (mode == MODE_EXT_A || mode == MODE_EXT_B) begin
      fn = FN_ADDR;
    end else if (mode == MODE_MIXED) begin
      fn = dir_bit ? FN_ADDR : FN_IN;
    end else begin
      fn = dir_bit ? FN_GPIO : FN_IN;
    end
    return fn;
  endfunction

  // Whether an address pin may drive in the present standby state.
  function automatic logic addr_may_drive(input logic sw, input logic hold);
    return !sw || hold;
  endfunction

endpackage

// File: rtl/xport_sync.sv
`timescale 1ns/1ps
module xport_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  localparam int LAST = STAGES - 1;

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[LAST];
endmodule

// File: rtl/xport_regs.sv
`timescale 1ns/1ps
module xport_regs
  import xport_pkg::*;
#(
  parameter int           W        = 8,
  parameter logic [W-1:0] DIR_FILL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hw_stby,
  input  logic         bus_wr,
  input  logic [1:0]   bus_sel,
  input  logic [W-1:0] bus_wdata,
  input  logic [W-1:0] pin_rb,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dat_q,
  output logic [W-1:0] puc_q,
  output logic [W-1:0] rd_data,
  output logic         wr_dir,
  output logic         wr_dat,
  output logic         wr_puc
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_sel);

  assign wr_dir = bus_wr && (sel == SEL_DIR);
  assign wr_dat = bus_wr && (sel == SEL_DAT);
  assign wr_puc = bus_wr && (sel == SEL_PUC);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q <= '0;
      dat_q <= '0;
      puc_q <= '0;
    end else begin
      if (hw_stby)     dir_q <= '0;
      else if (wr_dir) dir_q <= bus_wdata;
      if (wr_dat)      dat_q <= bus_wdata;
      if (wr_puc)      puc_q <= bus_wdata;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_DIR: rd_data = DIR_FILL;
      SEL_DAT: rd_data = dat_q;
      SEL_PIN: rd_data = pin_rb;
      SEL_PUC: rd_data = puc_q;
      default: rd_data = DIR_FILL;
    endcase
  end
endmodule

// File: rtl/xport_pin_cell.sv
`timescale 1ns/1ps
module xport_pin_cell
  import xport_pkg::*;
(
  input  pin_fn_e fn,
  input  logic    hw_stby,
  input  logic    sw_stby,
  input  logic    hold_en,
  input  logic    addr_bit,
  input  logic    hold_bit,
  input  logic    dat_bit,
  input  logic    puc_bit,
  input  logic    pad_bit,
  output logic    out_bit,
  output logic    oe_bit,
  output logic    pu_bit,
  output logic    rb_bit
);
  logic drive;

  always_comb begin
    unique case (fn)
      FN_ADDR: begin
        drive   = addr_may_drive(sw_stby, hold_en);
        out_bit = sw_stby ? hold_bit : addr_bit;
      end
      FN_GPIO: begin
        drive   = 1'b1;
        out_bit = dat_bit;
      end
      default: begin
        drive   = 1'b0;
        out_bit = 1'b0;
      end
    endcase
  end

  assign oe_bit = drive && !hw_stby;
  assign pu_bit = (fn == FN_IN) && puc_bit && !hw_stby;
  assign rb_bit = oe_bit ? out_bit : pad_bit;
endmodule

// File: rtl/xport_ctrl.sv
`timescale 1ns/1ps
module xport_ctrl
  import xport_pkg::*;
#(
  parameter int           W           = 8,
  parameter int           SYNC_STAGES = 2,
  parameter logic [W-1:0] DIR_FILL    = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_mode,
  input  logic         hw_stby,
  input  logic         sw_stby,
  input  logic         hold_en,
  input  logic [W-1:0] addr_in,
  input  logic         bus_wr,
  input  logic [1:0]   bus_sel,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] rd_data,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] pin_pu
);
  logic [W-1:0] dir_q, dat_q, puc_q;
  logic         wr_dir, wr_dat, wr_puc;
  logic [W-1:0] pad_sync;
  logic [W-1:0] pin_rb;
  logic [W-1:0] addr_hold_q;
  logic [W-1:0] addr_pin_mask;
  logic [W-1:0] input_mask;
  pin_fn_e      fn_vec [W];

  xport_regs #(.W(W), .DIR_FILL(DIR_FILL)) regs_i (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .pin_rb(pin_rb),
    .dir_q(dir_q), .dat_q(dat_q), .puc_q(puc_q), .rd_data(rd_data),
    .wr_dir(wr_dir), .wr_dat(wr_dat), .wr_puc(wr_puc)
  );

  xport_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(pad_in), .d_out(pad_sync)
  );

  // Address captured every cycle outside software standby.
  always_ff @(posedge clk) begin
    if (!rst_n)        addr_hold_q <= '0;
    else if (!sw_stby) addr_hold_q <= addr_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign fn_vec[i]        = pin_function(op_mode, dir_q[i]);
    assign addr_pin_mask[i] = (fn_vec[i] == FN_ADDR);
    assign input_mask[i]    = (fn_vec[i] == FN_IN);

    xport_pin_cell cell_i (
      .fn(fn_vec[i]), .hw_stby(hw_stby), .sw_stby(sw_stby), .hold_en(hold_en),
      .addr_bit(addr_in[i]), .hold_bit(addr_hold_q[i]), .dat_bit(dat_q[i]),
      .puc_bit(puc_q[i]), .pad_bit(pad_sync[i]),
      .out_bit(pin_out[i]), .oe_bit(pin_oe[i]), .pu_bit(pin_pu[i]), .rb_bit(pin_rb[i])
    );
  end
endmodule

// File: rtl/xport_chk.sv
`timescale 1ns/1ps
module xport_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   op_mode,
  input logic         hw_stby,
  input logic         sw_stby,
  input logic         hold_en,
  input logic [W-1:0] addr_in,
  input logic         bus_wr,
  input logic [1:0]   bus_sel,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] pin_out,
  input logic [W-1:0] pin_oe,
  input logic [W-1:0] pin_pu,
  input logic [W-1:0] dir_q,
  input logic [W-1:0] dat_q,
  input logic [W-1:0] addr_pin_mask,
  input logic [W-1:0] input_mask
);
  // R10
  hw_pins_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pin_oe == '0 && pin_pu == '0));

  // R10
  hw_dir_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |=> (dir_q == '0));

  // R7
  pu_not_driving_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pin_pu & pin_oe) == '0) && ((pin_pu & ~input_mask) == '0));

  // R2
  ext_mode_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_mode == 3'd4 || op_mode == 3'd5) && !hw_stby && !sw_stby)
      |-> (pin_oe == '1 && pin_out == addr_in));

  // R5
  dat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == 2'd1) |=> (dat_q == $past(bus_wdata)));

  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && hold_en && !hw_stby && $past(sw_stby) && $past(hold_en)
      && !$past(hw_stby) && $stable(op_mode) && $stable(dir_q))
      |-> (((pin_out ^ $past(pin_out)) & addr_pin_mask) == '0));

  // R9
  sw_dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !hw_stby && !(bus_wr && bus_sel == 2'd0)) |=> $stable(dir_q));
endmodule

bind xport_ctrl xport_chk #(.W(W)) chk_i (.*);

// File: tb/xport_ctrl_tb_top.sv
`timescale 1ns/1ps
module xport_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] op_mode;
  logic       hw_stby, sw_stby, hold_en;
  logic [7:0] addr_in, bus_wdata, pad_in;
  logic       bus_wr;
  logic [1:0] bus_sel;
  logic [7:0] rd_data, pin_out, pin_oe, pin_pu;

  always #2.5 clk = ~clk;

  xport_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .hold_en(hold_en), .addr_in(addr_in),
    .bus_wr(bus_wr), .bus_sel(bus_sel), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .pad_in(pad_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
  );

  typedef struct {
    string      req;
    int         kind;   // 0 rd_data, 1 pin_out under mask, 2 pin_oe, 3 pin_pu
    logic [7:0] exp;
    logic [7:0] mask;
  } item_t;

  item_t sb[$];
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;

  // Bench copy of software-visible state
  logic [7:0] m_dir, m_dat, m_puc, m_hold;

  function automatic void model(output logic [7:0] oe, output logic [7:0] val,
                                output logic [7:0] pu);
    for (int b = 0; b < 8; b++) begin
      bit ext   = (op_mode == 3'd4) || (op_mode == 3'd5);
      bit is_ad = ext || (op_mode == 3'd6 && m_dir[b]);
      bit is_gp = !ext && op_mode != 3'd6 && m_dir[b];
      bit drv   = is_ad ? (!sw_stby || hold_en) : is_gp;
      oe[b]  = drv && !hw_stby;
      val[b] = is_ad ? (sw_stby ? m_hold[b] : addr_in[b]) : m_dat[b];
      pu[b]  = !hw_stby && !is_ad && !is_gp && m_puc[b];
    end
  endfunction

  task automatic push(string req, int kind, logic [7:0] exp, logic [7:0] mask);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp; it.mask = mask;
    sb.push_back(it);
  endtask

  task automatic expect_pins(string req);
    logic [7:0] oe, val, pu;
    model(oe, val, pu);
    push(req, 2, oe, 8'hFF);
    push(req, 1, val & oe, oe);
    push(req, 3, pu, 8'hFF);
  endtask

  task automatic expect_read(string req, logic [1:0] sel, logic [7:0] exp);
    bus_sel = sel;
    push(req, 0, exp, 8'hFF);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic reg_write(logic [1:0] sel, logic [7:0] d);
    step();
    bus_wr = 1'b1; bus_sel = sel; bus_wdata = d;
    step();
    bus_wr = 1'b0;
    if (!hw_stby) begin
      if (sel == 2'd0) m_dir = d;
    end
    if (sel == 2'd1) m_dat = d;
    if (sel == 2'd3) m_puc = d;
  endtask

  // Monitor: pops and compares while the outputs are settled
  initial begin
    forever begin
      @(negedge clk);
      while (sb.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb.pop_front();
        case (it.kind)
          0:       got = rd_data;
          1:       got = pin_out & it.mask;
          2:       got = pin_oe;
          default: got = pin_pu;
        endcase
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] oe, val, pu;
    rst_n = 1'b0; op_mode = 3'd7; hw_stby = 1'b0; sw_stby = 1'b0; hold_en = 1'b0;
    addr_in = 8'h00; bus_wr = 1'b0; bus_sel = 2'd0; bus_wdata = 8'h00; pad_in = 8'h00;
    m_dir = 8'h00; m_dat = 8'h00; m_puc = 8'h00; m_hold = 8'h00;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset values and write-only filler
    expect_read("R1", 2'd0, 8'hFF);
    step(); expect_read("R1", 2'd1, 8'h00);
    step(); expect_read("R1", 2'd3, 8'h00);
    expect_pins("R1");

    // R4 / R5 general-purpose outputs in mode 7
    reg_write(2'd0, 8'hA5);
    reg_write(2'd1, 8'h3C);
    expect_pins("R4");
    expect_read("R5", 2'd1, 8'h3C);
    op_mode = 3'd2;                       // R4 other code behaves as mode 7
    expect_pins("R4");
    step(); op_mode = 3'd7;

    // R5 write to pin register ignored
    reg_write(2'd2, 8'hFF);
    expect_read("R5", 2'd1, 8'h3C);
    expect_pins("R5");
    step(); expect_read("R5", 2'd3, 8'h00);

    // R6 synchronized readback
    step(); pad_in = 8'h0F; bus_sel = 2'd2;
    step();
    model(oe, val, pu);
    expect_read("R6", 2'd2, (val & oe) | (8'h00 & ~oe));
    step();
    model(oe, val, pu);
    expect_read("R6", 2'd2, (val & oe) | (pad_in & ~oe));

    // R7 pull-ups on inputs only
    reg_write(2'd3, 8'hFF);
    expect_pins("R7");

    // R3 mixed mode
    step(); op_mode = 3'd6; addr_in = 8'h5A;
    expect_pins("R3");
    model(oe, val, pu);
    expect_read("R6", 2'd2, (val & oe) | (pad_in & ~oe));

    // R2 external address modes
    step(); op_mode = 3'd4;
    expect_pins("R2");
    step(); op_mode = 3'd5; addr_in = 8'hC3;
    expect_pins("R2");

    // R8 hold through software standby
    step(); op_mode = 3'd4; addr_in = 8'h11;
    step(); sw_stby = 1'b1; hold_en = 1'b1; addr_in = 8'h99; m_hold = 8'h11;
    expect_pins("R8");
    push("R8", 1, 8'h11, 8'hFF);
    step(); addr_in = 8'h77;
    expect_pins("R8");

    // R9 float address pins, GPIO keeps driving, direction retained
    step(); hold_en = 1'b0;
    expect_pins("R9");
    push("R9", 2, 8'h00, 8'hFF);
    step(); op_mode = 3'd7;
    expect_pins("R9");
    step(); sw_stby = 1'b0;
    expect_pins("R9");
    push("R9", 2, 8'hA5, 8'hFF);

    // R10 hardware standby
    step(); hw_stby = 1'b1;
    expect_pins("R10");
    reg_write(2'd0, 8'hFF);               // lost during hardware standby
    expect_pins("R10");
    step(); hw_stby = 1'b0; m_dir = 8'h00;
    expect_pins("R10");
    push("R10", 2, 8'h00, 8'hFF);
    expect_read("R10", 2'd1, 8'h3C);
    step(); expect_read("R10", 2'd3, 8'hFF);

    // R3 mixed mode with every direction bit clear
    step(); op_mode = 3'd6;
    expect_pins("R3");

    // R1 reset again
    step(); rst_n = 1'b0;
    step(); step(); rst_n = 1'b1;
    m_dir = 8'h00; m_dat = 8'h00; m_puc = 8'h00;
    op_mode = 3'd7;
    expect_read("R1", 2'd1, 8'h00);
    expect_pins("R1");

    repeat (3) step();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule